// File: doc/BRIEF.md
# LPC I/O Target Interface

This block is a target on a Low Pin Count bus. It serves single-byte I/O read and I/O write cycles that the host starts on the 4-bit multiplexed LAD lines. It runs on the bus clock, and each cycle is framed by the active-low frame strobe. When a cycle's 16-bit address falls inside a parameterised window, the block claims it and presents the address and byte on a simple local port. It then answers the host with SYNC nibbles, the read byte and a turnaround. Wider host accesses reach the block as separate one-byte cycles, so it carries no multi-byte logic.

A peripheral behind the local port holds `loc_ready` low to stretch the cycle for as long as it needs. The block always sends at least one wait nibble before the ready nibble, even when the peripheral is ready at once.

The active-low power-down input acts as a local reset for the bus sequencer only. While it is low, the sequencer is parked in idle and the LAD drivers are off. When it rises again, the block takes the next cycle without needing a bus reset.

Top module: `lpc_io_target`

## Requirements
- R1: After the synchronous active-high bus reset, `lad_oe`, `loc_wr` and `loc_rd` are all low, and the block waits for a start.
- R2: An I/O write is recognised as frame low with LAD 0000 (start), then nibble 0010, then four address nibbles most significant first, then two data nibbles low nibble first. While `loc_wr` is high, `loc_addr` and `loc_wdata` carry that address and byte.
- R3: An I/O read uses type nibble 0000. While `loc_rd` is high, `loc_addr` holds the address. The byte on `loc_rdata`, sampled in the clock where `loc_ready` is seen high, is driven back on the two clocks after the ready SYNC, low nibble first.
- R4: Every claimed transfer drives wait SYNC 0110 for at least one clock before ready SYNC 0000, even when `loc_ready` is already high. Each drive period begins with 0110.
- R5: While `loc_ready` is low, the block repeats 0110 and keeps its strobe (`loc_wr` or `loc_rd`) high.
- R6: The target turnaround drives 1111 for one clock, then releases LAD (`lad_oe` low) on the next. It comes after the ready SYNC for a write and after the second data nibble for a read.
- R7: Only addresses from BASE_ADDR to BASE_ADDR+WIN_SIZE-1 are claimed. For any other address, `lad_oe` and both strobes stay low for the rest of the cycle, and the next start is accepted.
- R8: A type nibble other than 0000 or 0010 makes the block ignore the cycle, with no LAD drive and no strobe.
- R9: Frame low in the middle of a cycle abandons it. With LAD 0000 it starts a new cycle; with any other value it returns to idle. Neither case drives LAD for the abandoned cycle.
- R10: While `pd_n` is low, `lad_oe` and both strobes are low, a cycle in progress is dropped, and start fields are ignored.
- R11: Once `pd_n` returns high, with no bus reset, the next cycle is served exactly as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Bus reset, synchronous, active high |
| pd_n | input | 1 | Power-down, active low; local reset of the bus sequencer |
| frame_n | input | 1 | Cycle frame strobe, active low |
| lad_in | input | 4 | LAD value seen on the bus |
| lad_out | output | 4 | LAD value the target drives |
| lad_oe | output | 1 | LAD output enable |
| loc_addr | output | 16 | Address of the claimed cycle |
| loc_wdata | output | 8 | Write byte of the claimed cycle |
| loc_rdata | input | 8 | Read byte from the peripheral |
| loc_wr | output | 1 | Write strobe, high through the wait SYNC clocks |
| loc_rd | output | 1 | Read strobe, high through the wait SYNC clocks |
| loc_ready | input | 1 | Peripheral ready; low stretches the cycle |

## Verification
The bench runs writes and reads at both edges of the window, with zero and several not-ready clocks. This separates the mandatory first wait nibble from waits that the peripheral causes, and it shows that the read byte is held from the ready clock and not taken live. Addresses just below and just above the window, and a memory-type nibble, confirm that unclaimed cycles never drive LAD. Frames re-asserted mid-cycle, once with a start value and once without, separate restart from abort. A power-down pulse during a stretched read, followed by a write with no bus reset, shows both the drop and the clean recovery.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int NIB_W     = 4;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int HTAR_CLKS = 2;
    localparam int CNT_W     = $clog2(ADDR_NIBS);

    localparam logic [NIB_W-1:0] NIB_START     = 4'h0;
    localparam logic [NIB_W-1:0] NIB_TYPE_IORD = 4'h0;
    localparam logic [NIB_W-1:0] NIB_TYPE_IOWR = 4'h2;
    localparam logic [NIB_W-1:0] NIB_SYNC_WAIT = 4'h6;
    localparam logic [NIB_W-1:0] NIB_SYNC_RDY  = 4'h0;
    localparam logic [NIB_W-1:0] NIB_TAR       = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTDIR,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR,
        ST_SWAIT,
        ST_SRDY,
        ST_RDATA,
        ST_TTAR_DRV,
        ST_TTAR_REL,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } io_req_t;

    typedef struct packed {
        logic             oe;
        logic [NIB_W-1:0] nib;
    } lad_drv_t;

    function automatic logic addr_in_window(input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] base,
                                            input logic [ADDR_W:0]   size);
        logic [ADDR_W:0] off;
        off = {1'b0, a} - {1'b0, base};
        return (a >= base) && (off < size);
    endfunction

endpackage

// File: rtl/lpc_addr_window.sv
module lpc_addr_window
    import lpc_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0380,
    parameter int unsigned       WIN_SIZE  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam bit POW2_ALIGNED = ((WIN_SIZE & (WIN_SIZE - 1)) == 0) &&
                                  ((int'(BASE_ADDR) % int'(WIN_SIZE)) == 0);
    localparam int SH = $clog2(WIN_SIZE);

    generate
        if (POW2_ALIGNED && SH < ADDR_W) begin : g_mask
            // Aligned power-of-two window: compare upper bits only.
            assign hit = (addr[ADDR_W-1:SH] == BASE_ADDR[ADDR_W-1:SH]);
        end else begin : g_range
            // General window: subtract and compare against the size.
            assign hit = addr_in_window(addr, BASE_ADDR, (ADDR_W+1)'(WIN_SIZE));
        end
    endgenerate

endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
    import lpc_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  lad_in,
    input  logic              loc_ready,
    input  logic [DATA_W-1:0] loc_rdata,
    input  logic              window_hit,
    output logic [ADDR_W-1:0] cand_addr,
    output bus_state_e        state,
    output io_req_t           req,
    output logic [DATA_W-1:0] rdata
);
    logic [CNT_W-1:0] cnt;

    // Address as it stands once the nibble on the bus is shifted in.
    assign cand_addr = {req.addr[ADDR_W-NIB_W-1:0], lad_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            req   <= '0;
            rdata <= '0;
        end else if (!pd_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (!frame_n) begin
            cnt   <= '0;
            state <= (lad_in == NIB_START) ? ST_CTDIR : ST_IDLE;
        end else begin
            case (state)
                ST_CTDIR: begin
                    cnt <= '0;
                    if (lad_in == NIB_TYPE_IORD) begin
                        req.is_write <= 1'b0;
                        state        <= ST_ADDR;
                    end else if (lad_in == NIB_TYPE_IOWR) begin
                        req.is_write <= 1'b1;
                        state        <= ST_ADDR;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    req.addr <= cand_addr;
                    if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
                        cnt <= '0;
                        if (!window_hit)       state <= ST_SKIP;
                        else if (req.is_write) state <= ST_WDATA;
                        else                   state <= ST_HTAR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    req.wdata <= {lad_in, req.wdata[DATA_W-1:NIB_W]};
                    if (cnt == CNT_W'(DATA_NIBS - 1)) begin
                        cnt   <= '0;
                        state <= ST_HTAR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HTAR: begin
                    if (cnt == CNT_W'(HTAR_CLKS - 1)) begin
                        cnt   <= '0;
                        state <= ST_SWAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SWAIT: begin
                    if (loc_ready) begin
                        state <= ST_SRDY;
                        if (!req.is_write) rdata <= loc_rdata;
                    end
                end
                ST_SRDY: begin
                    cnt   <= '0;
                    state <= req.is_write ? ST_TTAR_DRV : ST_RDATA;
                end
                ST_RDATA: begin
                    rdata <= rdata >> NIB_W;
                    if (cnt == CNT_W'(DATA_NIBS - 1)) begin
                        cnt   <= '0;
                        state <= ST_TTAR_DRV;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TTAR_DRV: state <= ST_TTAR_REL;
                ST_TTAR_REL: state <= ST_IDLE;
                default:     state <= state;
            endcase
        end
    end

    AST_PD_PARKS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!pd_n) |=> (state == ST_IDLE)); // R10

    AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRDY) |-> ($past(state) == ST_SWAIT)); // R4

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SWAIT && !loc_ready && pd_n && frame_n) |=> (state == ST_SWAIT)); // R5

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
    import lpc_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n,
    input  bus_state_e       state,
    input  logic             is_write,
    input  logic [NIB_W-1:0] rdata_nib,
    output logic [NIB_W-1:0] lad_out,
    output logic             lad_oe,
    output logic             loc_wr,
    output logic             loc_rd
);
    lad_drv_t drv;

    always_comb begin
        drv = '{oe: 1'b0, nib: NIB_TAR};
        case (state)
            ST_SWAIT:    drv = '{oe: 1'b1, nib: NIB_SYNC_WAIT};
            ST_SRDY:     drv = '{oe: 1'b1, nib: NIB_SYNC_RDY};
            ST_RDATA:    drv = '{oe: 1'b1, nib: rdata_nib};
            ST_TTAR_DRV: drv = '{oe: 1'b1, nib: NIB_TAR};
            default:     drv = '{oe: 1'b0, nib: NIB_TAR};
        endcase
    end

    // Power-down disables the drivers in the same clock it is seen.
    assign lad_out = drv.nib;
    assign lad_oe  = drv.oe & pd_n;
    assign loc_wr  = (state == ST_SWAIT) &  is_write & pd_n;
    assign loc_rd  = (state == ST_SWAIT) & ~is_write & pd_n;

    AST_DRIVE_OPENS_WITH_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(lad_oe) |-> (lad_out == NIB_SYNC_WAIT)); // R4

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(loc_wr && loc_rd)); // R2

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0380,
    parameter int unsigned       WIN_SIZE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  lad_in,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              loc_wr,
    output logic              loc_rd,
    input  logic              loc_ready
);
    logic [ADDR_W-1:0] cand_addr;
    logic              window_hit;
    bus_state_e        state;
    io_req_t           req;
    logic [DATA_W-1:0] rdata;

    lpc_addr_window #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_SIZE  (WIN_SIZE)
    ) u_window (
        .addr (cand_addr),
        .hit  (window_hit)
    );

    lpc_cycle_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pd_n       (pd_n),
        .frame_n    (frame_n),
        .lad_in     (lad_in),
        .loc_ready  (loc_ready),
        .loc_rdata  (loc_rdata),
        .window_hit (window_hit),
        .cand_addr  (cand_addr),
        .state      (state),
        .req        (req),
        .rdata      (rdata)
    );

    lpc_lad_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .state     (state),
        .is_write  (req.is_write),
        .rdata_nib (rdata[NIB_W-1:0]),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .loc_wr    (loc_wr),
        .loc_rd    (loc_rd)
    );

    assign loc_addr  = req.addr;
    assign loc_wdata = req.wdata;

endmodule

// File: tb/test_lpc_io_target.sv
module test_lpc_io_target;

    localparam logic [15:0] BASE = 16'h0380;
    localparam int unsigned SIZE = 16;

    logic        clk = 1'b0;
    logic        rst, pd_n, frame_n, loc_ready;
    logic [3:0]  lad_in;
    logic [7:0]  loc_rdata;
    logic [3:0]  lad_out;
    logic        lad_oe, loc_wr, loc_rd;
    logic [15:0] loc_addr;
    logic [7:0]  loc_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_addr;
    logic [7:0]  exp_wdata;

    // Reference model: per-clock stimulus and expected bus response.
    logic [14:0] stim_q[$];   // {pd_n, frame_n, lad, ready, rdata}
    logic [6:0]  exp_q[$];    // {oe, lad, wr, rd}
    string       tag_q[$];

    lpc_io_target #(.BASE_ADDR(BASE), .WIN_SIZE(SIZE)) i_lpc_io_target (
        .clk(clk), .rst(rst), .pd_n(pd_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_ready(loc_ready)
    );

    always #5 clk = ~clk;

    task automatic push(input logic pd, input logic fr, input logic [3:0] lad,
                        input logic rdy, input logic [7:0] rd,
                        input logic eoe, input logic [3:0] elad,
                        input logic ewr, input logic erd, input string tag);
        stim_q.push_back({pd, fr, lad, rdy, rd});
        exp_q.push_back({eoe, elad, ewr, erd});
        tag_q.push_back(tag);
    endtask

    task automatic quiet(input logic fr, input logic [3:0] lad, input string tag);
        push(1'b1, fr, lad, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0, 1'b0, tag);
    endtask

    task automatic compare(input logic [6:0] e, input string tag);
        logic ok;
        ok = (lad_oe === e[6]) && (loc_wr === e[1]) && (loc_rd === e[0]);
        if (e[6])        ok = ok && (lad_out === e[5:2]);
        if (e[1] | e[0]) ok = ok && (loc_addr === exp_addr);
        if (e[1])        ok = ok && (loc_wdata === exp_wdata);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual oe=%0b lad=%h wr=%0b rd=%0b addr=%h wdata=%h; expected oe=%0b lad=%h wr=%0b rd=%0b addr=%h wdata=%h",
                     tag, lad_oe, lad_out, loc_wr, loc_rd, loc_addr, loc_wdata,
                     e[6], e[5:2], e[1], e[0], exp_addr, exp_wdata);
        end
    endtask

    task automatic run_q;
        while (stim_q.size() > 0) begin
            logic [14:0] s;
            logic [6:0]  e;
            string       t;
            s = stim_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            {pd_n, frame_n, lad_in, loc_ready, loc_rdata} = s;
            @(posedge clk);
            @(negedge clk);
            compare(e, t);
        end
    endtask

    task automatic addr_nibs(input logic [15:0] a, input string tag);
        for (int i = 0; i < 4; i++) quiet(1'b1, a[15-4*i -: 4], tag);
    endtask

    // One whole host cycle with its expected target response.
    task automatic io_cycle(input logic wr, input logic [15:0] a, input logic [7:0] d,
                            input int waits, input string tag);
        logic hit;
        hit = (a >= BASE) && (32'(a) < 32'(BASE) + SIZE);
        exp_addr = a;
        if (wr) exp_wdata = d;
        quiet(1'b0, 4'h0, tag);
        quiet(1'b1, wr ? 4'h2 : 4'h0, tag);
        addr_nibs(a, tag);
        if (wr) begin
            quiet(1'b1, d[3:0], tag);
            quiet(1'b1, d[7:4], tag);
        end
        quiet(1'b1, 4'hF, tag);
        push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, hit, 4'h6, hit & wr, hit & ~wr, tag);
        for (int w = 0; w < waits; w++)
            push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, hit, 4'h6, hit & wr, hit & ~wr, tag);
        push(1'b1, 1'b1, 4'hF, 1'b1, d, hit, 4'h0, 1'b0, 1'b0, tag);
        if (!wr) begin
            push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, hit, d[3:0], 1'b0, 1'b0, tag);
            push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, hit, d[7:4], 1'b0, 1'b0, tag);
        end
        push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, hit, 4'hF, 1'b0, 1'b0, tag);
        quiet(1'b1, 4'hF, tag);
        quiet(1'b1, 4'hF, tag);
        run_q();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; pd_n = 1'b1; frame_n = 1'b1; lad_in = 4'hF;
        loc_ready = 1'b0; loc_rdata = 8'h00;
        exp_addr = '0; exp_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(7'b0_1111_0_0, "R1 in reset");
        rst = 1'b0;
        quiet(1'b1, 4'hF, "R1");
        quiet(1'b1, 4'hF, "R1");
        run_q();

        // R2 / R4 / R6: writes, ready at once and after waits, window edges
        io_cycle(1'b1, 16'h0384, 8'hA5, 0, "R2 R4 R6 write ready at once");
        io_cycle(1'b1, 16'h038F, 8'h3C, 3, "R5 write top of window stretched");
        // R3: reads
        io_cycle(1'b0, 16'h0380, 8'h5A, 0, "R3 R4 read base of window");
        io_cycle(1'b0, 16'h0381, 8'hC3, 2, "R3 R5 read stretched");

        // R7: just outside the window on both sides, then a claimed cycle
        io_cycle(1'b1, 16'h0390, 8'h11, 0, "R7 write above window");
        io_cycle(1'b0, 16'h037F, 8'h22, 1, "R7 read below window");
        io_cycle(1'b1, 16'h0385, 8'h69, 0, "R7 next start after miss");

        // R8: memory-type nibble with an in-window address
        quiet(1'b0, 4'h0, "R8");
        quiet(1'b1, 4'h4, "R8");
        addr_nibs(16'h0384, "R8");
        for (int i = 0; i < 6; i++) quiet(1'b1, 4'hF, "R8 unknown type");
        run_q();

        // R9: restart with a start value in the middle of an address
        quiet(1'b0, 4'h0, "R9");
        quiet(1'b1, 4'h2, "R9");
        quiet(1'b1, 4'h0, "R9");
        quiet(1'b1, 4'h3, "R9");
        run_q();
        io_cycle(1'b0, 16'h0382, 8'h96, 1, "R9 restart mid cycle");
        // R9: abort with a non-start value during write data
        quiet(1'b0, 4'h0, "R9");
        quiet(1'b1, 4'h2, "R9");
        addr_nibs(16'h0384, "R9");
        quiet(1'b1, 4'h7, "R9");
        quiet(1'b0, 4'hF, "R9 abort");
        for (int i = 0; i < 5; i++) quiet(1'b1, 4'hF, "R9 abort no drive");
        run_q();

        // R10: power-down during a stretched read
        exp_addr = 16'h0386;
        quiet(1'b0, 4'h0, "R10");
        quiet(1'b1, 4'h0, "R10");
        addr_nibs(16'h0386, "R10");
        quiet(1'b1, 4'hF, "R10");
        push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, 1'b1, 4'h6, 1'b0, 1'b1, "R10 wait before pd");
        push(1'b1, 1'b1, 4'hF, 1'b0, 8'h00, 1'b1, 4'h6, 1'b0, 1'b1, "R10 wait before pd");
        push(1'b0, 1'b1, 4'hF, 1'b1, 8'h44, 1'b0, 4'hF, 1'b0, 1'b0, "R10 pd drops cycle");
        push(1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0, 1'b0, "R10 start ignored");
        push(1'b0, 1'b1, 4'h0, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0, 1'b0, "R10 held idle");
        push(1'b0, 1'b1, 4'hF, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0, 1'b0, "R10 held idle");
        quiet(1'b1, 4'hF, "R11 released");
        run_q();
        // R11: no bus reset, next cycles served normally
        io_cycle(1'b1, 16'h038A, 8'h7E, 0, "R11 write after pd");
        io_cycle(1'b0, 16'h038A, 8'hE7, 1, "R11 read after pd");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule